// File: doc/BRIEF.md
# Multi-Mode Legacy Timer/Counter

A timer/counter built from two 8-bit count halves that can be arranged as a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself from the high half, or two independent 8-bit counters. It is compatible with the classic 8-bit microcontroller timer behaviour. Each count step is triggered by one selectable source: the system clock, one of three fixed prescaled versions of it, an external clock divided down, or falling edges on a count pin.

The host controls the block through its mode and source selects, a run bit with an optional gate pin, write strobes that load either half, and clear strobes for the overflow flags. A parameter decides whether this instance supports the split dual-8-bit arrangement. An instance without it holds its count in that mode.

Top module: `ltmr_top`

## Requirements
- R1: After reset both count halves read 0 and both overflow flags are clear.
- R2: src_sel_i picks the count tick as follows. 0 selects every system clock. 1, 2 and 3 select the system clock divided by 4, 12 and 48. 4 selects one step per 8 rising edges of ext_clk_i. 5 selects one step per falling edge of cnt_pin_i. Values 6 and 7 give no step. Both pins pass through a two-flop synchroniser.
- R3: With mode_i = 1, {cnt_hi_o, cnt_lo_o} counts as one 16-bit value. It wraps from FFFF to 0000, and the wrap sets ovf_o.
- R4: With mode_i = 0, bits [4:0] of cnt_lo_o count and carry into cnt_hi_o, while bits [7:5] of cnt_lo_o are left untouched. A step with cnt_hi_o = FF and field = 1F wraps to zero and sets ovf_o.
- R5: With mode_i = 2, cnt_lo_o counts. On a step from FF it takes the value of cnt_hi_o and sets ovf_o, and cnt_hi_o never changes by counting.
- R6: With mode_i = 3 on an instance built with SPLIT_EN = 1, the two halves are independent. cnt_lo_o counts on the selected tick under run/gate and sets ovf_o on wrap. cnt_hi_o counts on the system clock divided by 12 while run_hi_i is high and sets ovf_hi_o on wrap.
- R7: On an instance built with SPLIT_EN = 0, mode_i = 3 holds both halves and sets no flag.
- R8: While run_i is low, the count selected by src_sel_i does not advance.
- R9: With gate_en_i high, counting advances only while the synchronised gate_pin_i is also high.
- R10: An overflow flag stays set until its clear strobe is pulsed. If an overflow and a clear fall in the same cycle, the flag ends set.
- R11: wr_lo_i or wr_hi_i loads wr_data_i into that half on the next clock edge. The load takes precedence over a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Count arrangement: 0 13-bit, 1 16-bit, 2 8-bit reload, 3 split |
| src_sel_i | input | 3 | Count tick source select |
| run_i | input | 1 | Run bit for the main count |
| gate_en_i | input | 1 | Makes counting also depend on gate_pin_i |
| gate_pin_i | input | 1 | External gate level |
| run_hi_i | input | 1 | Run bit for the high half in split mode |
| ext_clk_i | input | 1 | External clock, divided by 8 when selected |
| cnt_pin_i | input | 1 | External count pin, falling edges counted |
| wr_lo_i | input | 1 | Load low half from wr_data_i |
| wr_hi_i | input | 1 | Load high half from wr_data_i |
| wr_data_i | input | 8 | Load data |
| ovf_clr_i | input | 1 | Clear ovf_o |
| ovf_hi_clr_i | input | 1 | Clear ovf_hi_o |
| cnt_lo_o | output | 8 | Low count half |
| cnt_hi_o | output | 8 | High count half |
| ovf_o | output | 1 | Main overflow flag |
| ovf_hi_o | output | 1 | High-half overflow flag (split mode) |

## Verification
The checker watches these properties on every cycle: holding while stopped, single-step progress in 16-bit mode, the untouched upper low-byte bits in 13-bit mode, the reload value when the flag rises in reload mode, flag persistence, and the hold on an instance without split support. Exact tick rates, the synchroniser delay on pins and the gate, the positions of wraps, and the rule that a set wins over a clear can only be shown by the bench scenarios. Those scenarios measure count differences over windows whose length is a whole multiple of the divider period.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
  typedef enum logic [1:0] {
    MODE_13      = 2'd0,
    MODE_16      = 2'd1,
    MODE_RELOAD8 = 2'd2,
    MODE_SPLIT   = 2'd3
  } ltmr_mode_e;

  typedef enum logic [2:0] {
    SRC_SYS   = 3'd0,
    SRC_DIV_A = 3'd1,
    SRC_DIV_B = 3'd2,
    SRC_DIV_C = 3'd3,
    SRC_EXT   = 3'd4,
    SRC_PIN   = 3'd5
  } ltmr_src_e;
endpackage

// File: rtl/ltmr_sync.sv
module ltmr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign lvl_o = sh_q[STAGES-1];
endmodule

// File: rtl/ltmr_div.sv
module ltmr_div #(
  parameter int unsigned N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (N > 2) ? $clog2(N) : 1;
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + W'(1);
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/ltmr_tick_gen.sv
module ltmr_tick_gen
  import ltmr_pkg::*;
#(
  parameter int unsigned DIV_A       = 4,
  parameter int unsigned DIV_B       = 12,
  parameter int unsigned DIV_C       = 48,
  parameter int unsigned EXT_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ltmr_src_e src_i,
  input  logic      ext_clk_i,
  input  logic      cnt_pin_i,
  input  logic      gate_pin_i,
  output logic      tick_o,
  output logic      tick_b_o,
  output logic      gate_lvl_o
);
  localparam int unsigned NDIV = 3;
  localparam int unsigned DIVS [NDIV] = '{DIV_A, DIV_B, DIV_C};

  logic [NDIV-1:0] pre_tick;

  for (genvar g = 0; g < NDIV; g++) begin : g_pre
    ltmr_div #(.N(DIVS[g])) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (1'b1),
      .tick_o (pre_tick[g])
    );
  end

  logic ext_lvl, ext_d_q, pin_lvl, pin_d_q;

  ltmr_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_clk_i), .lvl_o(ext_lvl));
  ltmr_sync #(.STAGES(SYNC_STAGES)) u_sync_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cnt_pin_i), .lvl_o(pin_lvl));
  ltmr_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_pin_i), .lvl_o(gate_lvl_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_d_q <= 1'b0;
      pin_d_q <= 1'b0;
    end else begin
      ext_d_q <= ext_lvl;
      pin_d_q <= pin_lvl;
    end
  end

  logic ext_rise, pin_fall, ext_tick;
  assign ext_rise = ext_lvl & ~ext_d_q;
  assign pin_fall = pin_d_q & ~pin_lvl;

  ltmr_div #(.N(EXT_DIV)) u_ext_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ext_rise),
    .tick_o (ext_tick)
  );

  always_comb begin
    unique case (src_i)
      SRC_SYS:   tick_o = 1'b1;
      SRC_DIV_A: tick_o = pre_tick[0];
      SRC_DIV_B: tick_o = pre_tick[1];
      SRC_DIV_C: tick_o = pre_tick[2];
      SRC_EXT:   tick_o = ext_tick;
      SRC_PIN:   tick_o = pin_fall;
      default:   tick_o = 1'b0;
    endcase
  end

  assign tick_b_o = pre_tick[1];
endmodule

// File: rtl/ltmr_core.sv
module ltmr_core
  import ltmr_pkg::*;
#(
  parameter int unsigned HW       = 8,
  parameter int unsigned FW       = 5,
  parameter bit          SPLIT_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ltmr_mode_e    mode_i,
  input  logic          en_lo_i,
  input  logic          en_hi_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [HW-1:0] wr_data_i,
  output logic [HW-1:0] lo_o,
  output logic [HW-1:0] hi_o,
  output logic          ovf_evt_o,
  output logic          ovf_hi_evt_o
);
  localparam int unsigned CW = 2 * HW;

  logic [HW-1:0] lo_q, hi_q, lo_n, hi_n;

  always_comb begin
    lo_n         = lo_q;
    hi_n         = hi_q;
    ovf_evt_o    = 1'b0;
    ovf_hi_evt_o = 1'b0;
    unique case (mode_i)
      MODE_13: if (en_lo_i) begin
        if (&lo_q[FW-1:0]) begin
          lo_n[FW-1:0] = '0;
          hi_n         = hi_q + HW'(1);
          ovf_evt_o    = &hi_q;
        end else begin
          lo_n[FW-1:0] = lo_q[FW-1:0] + FW'(1);
        end
      end
      MODE_16: if (en_lo_i) begin
        {hi_n, lo_n} = {hi_q, lo_q} + CW'(1);
        ovf_evt_o    = &{hi_q, lo_q};
      end
      MODE_RELOAD8: if (en_lo_i) begin
        if (&lo_q) begin
          lo_n      = hi_q;
          ovf_evt_o = 1'b1;
        end else begin
          lo_n = lo_q + HW'(1);
        end
      end
      default: if (SPLIT_EN) begin
        if (en_lo_i) begin
          lo_n      = lo_q + HW'(1);
          ovf_evt_o = &lo_q;
        end
        if (en_hi_i) begin
          hi_n         = hi_q + HW'(1);
          ovf_hi_evt_o = &hi_q;
        end
      end
    endcase
    if (wr_lo_i) lo_n = wr_data_i;
    if (wr_hi_i) hi_n = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/ltmr_flag.sv
module ltmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/ltmr_top.sv
module ltmr_top
  import ltmr_pkg::*;
#(
  parameter int unsigned HW          = 8,
  parameter int unsigned FW          = 5,
  parameter int unsigned DIV_A       = 4,
  parameter int unsigned DIV_B       = 12,
  parameter int unsigned DIV_C       = 48,
  parameter int unsigned EXT_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          SPLIT_EN    = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [2:0]    src_sel_i,
  input  logic          run_i,
  input  logic          gate_en_i,
  input  logic          gate_pin_i,
  input  logic          run_hi_i,
  input  logic          ext_clk_i,
  input  logic          cnt_pin_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [HW-1:0] wr_data_i,
  input  logic          ovf_clr_i,
  input  logic          ovf_hi_clr_i,
  output logic [HW-1:0] cnt_lo_o,
  output logic [HW-1:0] cnt_hi_o,
  output logic          ovf_o,
  output logic          ovf_hi_o
);
  logic tick, tick_b, gate_lvl, run_ok, ovf_evt, ovf_hi_evt;

  ltmr_tick_gen #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C),
    .EXT_DIV(EXT_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (ltmr_src_e'(src_sel_i)),
    .ext_clk_i  (ext_clk_i),
    .cnt_pin_i  (cnt_pin_i),
    .gate_pin_i (gate_pin_i),
    .tick_o     (tick),
    .tick_b_o   (tick_b),
    .gate_lvl_o (gate_lvl)
  );

  assign run_ok = run_i & (~gate_en_i | gate_lvl);

  ltmr_core #(.HW(HW), .FW(FW), .SPLIT_EN(SPLIT_EN)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (ltmr_mode_e'(mode_i)),
    .en_lo_i      (tick & run_ok),
    .en_hi_i      (tick_b & run_hi_i),
    .wr_lo_i      (wr_lo_i),
    .wr_hi_i      (wr_hi_i),
    .wr_data_i    (wr_data_i),
    .lo_o         (cnt_lo_o),
    .hi_o         (cnt_hi_o),
    .ovf_evt_o    (ovf_evt),
    .ovf_hi_evt_o (ovf_hi_evt)
  );

  ltmr_flag u_flag_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ovf_evt), .clr_i(ovf_clr_i), .q_o(ovf_o));
  ltmr_flag u_flag_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ovf_hi_evt), .clr_i(ovf_hi_clr_i), .q_o(ovf_hi_o));
endmodule

// File: rtl/ltmr_chk.sv
module ltmr_chk #(
  parameter int unsigned HW       = 8,
  parameter int unsigned FW       = 5,
  parameter bit          SPLIT_EN = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          run_i,
  input logic          run_hi_i,
  input logic          wr_lo_i,
  input logic          wr_hi_i,
  input logic          ovf_clr_i,
  input logic          ovf_hi_clr_i,
  input logic [HW-1:0] cnt_lo_o,
  input logic [HW-1:0] cnt_hi_o,
  input logic          ovf_o,
  input logic          ovf_hi_o
);
  logic no_wr;
  assign no_wr = !wr_lo_i && !wr_hi_i;

  p_hold_stopped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd3 && !run_i && no_wr) |=> ($stable(cnt_lo_o) && $stable(cnt_hi_o)));

  p_single_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && no_wr) |=>
      ({cnt_hi_o, cnt_lo_o} == $past({cnt_hi_o, cnt_lo_o}) ||
       {cnt_hi_o, cnt_lo_o} == $past({cnt_hi_o, cnt_lo_o}) + (2*HW)'(1)));

  p_upper_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !wr_lo_i) |=> $stable(cnt_lo_o[HW-1:FW]));

  p_reload_value_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ovf_o) && $past(mode_i) == 2'd2 && !$past(wr_lo_i) && !$past(wr_hi_i))
      |-> (cnt_lo_o == $past(cnt_hi_o)));

  p_hi_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && !run_hi_i && !wr_hi_i) |=> $stable(cnt_hi_o));

  p_nosplit_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!SPLIT_EN && mode_i == 2'd3 && no_wr) |=> ($stable(cnt_lo_o) && $stable(cnt_hi_o)));

  p_nosplit_noflag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!SPLIT_EN && mode_i == 2'd3 && !ovf_o) |=> !ovf_o);

  p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  p_hi_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_hi_o && !ovf_hi_clr_i) |=> ovf_hi_o);
endmodule

bind ltmr_top ltmr_chk #(.HW(HW), .FW(FW), .SPLIT_EN(SPLIT_EN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .run_i        (run_i),
  .run_hi_i     (run_hi_i),
  .wr_lo_i      (wr_lo_i),
  .wr_hi_i      (wr_hi_i),
  .ovf_clr_i    (ovf_clr_i),
  .ovf_hi_clr_i (ovf_hi_clr_i),
  .cnt_lo_o     (cnt_lo_o),
  .cnt_hi_o     (cnt_hi_o),
  .ovf_o        (ovf_o),
  .ovf_hi_o     (ovf_hi_o)
);

// File: tb/sim_ltmr_top.sv
module sim_ltmr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd1;
  logic [2:0] src = 3'd0;
  logic       run = 1'b0, gate_en = 1'b0, gate_pin = 1'b0, run_hi = 1'b0;
  logic       ext_clk = 1'b0, cnt_pin = 1'b1;
  logic       wr_lo = 1'b0, wr_hi = 1'b0, clr = 1'b0, clr_hi = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] lo0, hi0, lo1, hi1;
  logic       ovf0, ovfh0, ovf1, ovfh1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;
  always #60 ext_clk = ~ext_clk;

  ltmr_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .src_sel_i(src), .run_i(run),
    .gate_en_i(gate_en), .gate_pin_i(gate_pin), .run_hi_i(run_hi),
    .ext_clk_i(ext_clk), .cnt_pin_i(cnt_pin), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wr_data_i(wdata), .ovf_clr_i(clr), .ovf_hi_clr_i(clr_hi),
    .cnt_lo_o(lo0), .cnt_hi_o(hi0), .ovf_o(ovf0), .ovf_hi_o(ovfh0));

  ltmr_top #(.SPLIT_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .src_sel_i(src), .run_i(run),
    .gate_en_i(gate_en), .gate_pin_i(gate_pin), .run_hi_i(run_hi),
    .ext_clk_i(ext_clk), .cnt_pin_i(cnt_pin), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wr_data_i(wdata), .ovf_clr_i(clr), .ovf_hi_clr_i(clr_hi),
    .cnt_lo_o(lo1), .cnt_hi_o(hi1), .ovf_o(ovf1), .ovf_hi_o(ovfh1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] l, input logic [7:0] h);
    @(negedge clk); wr_lo = 1'b1; wdata = l;
    @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wdata = h;
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); clr = 1'b1; clr_hi = 1'b1;
    @(negedge clk); clr = 1'b0; clr_hi = 1'b0;
  endtask

  task automatic run_for(input int n);
    @(negedge clk); run = 1'b1;
    wait_n(n);
    run = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 lo", lo0, 0); chk("R1 hi", hi0, 0);
    chk("R1 flags", {ovf0, ovfh0, ovf1, ovfh1}, 0);
  endtask

  task automatic t_sixteen();
    mode = 2'd1; src = 3'd0;
    load(8'hFD, 8'hFF);
    chk("R11 load", {hi0, lo0}, 16'hFFFD);
    run_for(5);
    chk("R3 wrap", {hi0, lo0}, 16'h0002);
    chk("R3 ovf", ovf0, 1);
    wait_n(20);
    chk("R8 hold", {hi0, lo0}, 16'h0002);
    chk("R10 sticky", ovf0, 1);
    clear_flags();
    chk("R10 clear", ovf0, 0);
  endtask

  task automatic t_thirteen();
    mode = 2'd0; src = 3'd0;
    load(8'hFE, 8'h12);
    run_for(3);
    chk("R4 carry", {hi0, lo0}, 16'h13E1);
    chk("R4 no ovf", ovf0, 0);
    load(8'hBF, 8'hFF);
    run_for(1);
    chk("R4 wrap", {hi0, lo0}, 16'h00A0);
    chk("R4 ovf", ovf0, 1);
    clear_flags();
  endtask

  task automatic t_reload();
    mode = 2'd2; src = 3'd0;
    load(8'hFE, 8'h80);
    run_for(3);
    chk("R5 reload", {hi0, lo0}, 16'h8081);
    chk("R5 ovf", ovf0, 1);
    clear_flags();
    load(8'hFF, 8'h40);
    @(negedge clk); run = 1'b1; clr = 1'b1;
    @(negedge clk); run = 1'b0; clr = 1'b0;
    chk("R10 set wins", ovf0, 1);
    chk("R5 reload2", lo0, 8'h40);
    clear_flags();
  endtask

  task automatic t_rate(input logic [2:0] s, input int win, input int exp_d, input string tag);
    logic [15:0] a;
    mode = 2'd1; src = s;
    load(8'h00, 8'h00);
    @(negedge clk); run = 1'b1;
    wait_n(100);
    a = {hi0, lo0};
    wait_n(win);
    chk(tag, 32'({hi0, lo0} - a), exp_d);
    run = 1'b0;
  endtask

  task automatic t_pin();
    mode = 2'd1; src = 3'd5;
    load(8'h00, 8'h00);
    @(negedge clk); run = 1'b1;
    wait_n(6);
    for (int i = 0; i < 5; i++) begin
      cnt_pin = 1'b0; wait_n(3);
      cnt_pin = 1'b1; wait_n(3);
    end
    wait_n(6);
    run = 1'b0;
    chk("R2 pin falls", {hi0, lo0}, 5);
  endtask

  task automatic t_gate();
    logic [15:0] a;
    mode = 2'd1; src = 3'd0;
    load(8'h00, 8'h00);
    @(negedge clk); gate_en = 1'b1; gate_pin = 1'b0; run = 1'b1;
    wait_n(20);
    chk("R9 gate low", {hi0, lo0}, 0);
    gate_pin = 1'b1; wait_n(5);
    a = {hi0, lo0}; wait_n(10);
    chk("R9 gate high", 32'({hi0, lo0} - a), 10);
    gate_pin = 1'b0; wait_n(5);
    a = {hi0, lo0}; wait_n(10);
    chk("R9 gate closed", 32'({hi0, lo0} - a), 0);
    run = 1'b0; gate_en = 1'b0;
  endtask

  task automatic t_split();
    clear_flags();
    mode = 2'd3; src = 3'd0; run_hi = 1'b0;
    load(8'hF0, 8'h00);
    run_for(16);
    chk("R6 lo wrap", lo0, 8'h00);
    chk("R6 lo ovf", ovf0, 1);
    chk("R6 hi idle", hi0, 8'h00);
    chk("R7 held", {hi1, lo1}, 16'h00F0);
    chk("R7 no flag", ovf1, 0);
    load(8'h33, 8'hFE);
    @(negedge clk); run_hi = 1'b1;
    wait_n(36);
    run_hi = 1'b0;
    chk("R6 hi count", hi0, 8'h01);
    chk("R6 hi ovf", ovfh0, 1);
    chk("R6 lo still", lo0, 8'h33);
    chk("R7 held hi", hi1, 8'hFE);
    chk("R7 no hi flag", ovfh1, 0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_sixteen();
    t_thirteen();
    t_reload();
    t_rate(3'd0, 30, 30, "R2 sys");
    t_rate(3'd1, 80, 20, "R2 div4");
    t_rate(3'd2, 120, 10, "R2 div12");
    t_rate(3'd3, 480, 10, "R2 div48");
    t_rate(3'd4, 480, 10, "R2 ext div8");
    t_rate(3'd6, 50, 0, "R2 no source");
    t_pin();
    t_gate();
    t_split();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule